// File: doc/BRIEF.md
# Calibration Step Sequencer

This block drives a four-stage self-calibration of a phase-measurement front end. A rising edge on the start request launches a run. All four trim codes are first reloaded with the middle of their range. The block then visits, in a fixed order, the offset cancel stage, the clock pulse-width stage, the data rising-edge delay stage and the data falling-edge delay stage. For each stage it raises one injection select, so that the analog side routes the right test signal to its charge pump. It then searches that stage's trim code bit by bit, using a single comparator that reports whether the output sits above the reference level.

A programmable settle count sets how many clock cycles each trial code is given before the comparator is sampled. When the last stage resolves, the block pulls its open-drain calibrated monitor low and emits a one-cycle request to clear the start bit. A bypass input tells the analog side to ignore the trims once the block is idle, but a run in progress always applies its trims. A sleep input freezes the whole sequencer and keeps every trim code intact.

Top module: `calseq_top`

## Requirements
- R1: Directly after reset, every trim output equals the mid code (only the MSB set, 32 for 6 bits), the monitor pull is 0, the clear-start pulse is 0, all injection selects are 0 and trim_apply_o is 1.
- R2: A run is launched by a 0-to-1 change of start_i seen at a clock edge while sleep_i is 0. At that edge every trim code is reloaded with the mid code.
- R3: Stages run in the fixed order offset, duty, rise, fall. inj_sel_o is one-hot while a run is active, with bit 0 for offset, bit 1 for duty, bit 2 for rise and bit 3 for fall, and it is all zero when idle.
- R4: Each stage is a binary search from the MSB down, one comparator sample per bit. cmp_i = 1 means the trial code is too high and clears that bit. A trial is held for settle_i + 1 cycles, so a run lasts 4 × TRIM_W × (settle_i + 1) cycles and ends with each trim equal to the threshold the comparator implements (0 to 63 included).
- R5: mon_pull_o is 0 during the whole run, becomes 1 when the run completes, and stays 1 until the next launch.
- R6: clr_start_o is a single-cycle pulse in the first idle cycle after completion, and it is 0 otherwise.
- R7: trim_apply_o is 1 whenever a run is active. When idle it equals the inverse of bypass_i, so a run started with bypass high still completes and its result is bypassed at once.
- R8: A new rising edge of start_i during a run restarts from the offset stage with mid codes, and the run then lasts the full length from that edge.
- R9: While sleep_i is 1 the sequencer makes no progress and every trim output holds its value. A run paused by sleep resumes where it stopped.
- R10: A start rising edge that happens while asleep is not acted on until sleep_i falls, and it then launches a run.
- R11: While a stage is searched, stages already finished show their result and stages not yet reached show the mid code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_i | input | 1 | Start request bit, launches on rising edge |
| bypass_i | input | 1 | Bypass request for the trimmed signals |
| sleep_i | input | 1 | Sleep bit, freezes the sequencer |
| cmp_i | input | 1 | Comparator: 1 = output above reference |
| settle_i | input | CNT_W | Settle cycles added before each sample |
| trim_offset_o | output | TRIM_W | Offset cancel trim code |
| trim_duty_o | output | TRIM_W | Clock pulse-width trim code |
| trim_rise_o | output | TRIM_W | Data rising-edge delay trim code |
| trim_fall_o | output | TRIM_W | Data falling-edge delay trim code |
| trim_apply_o | output | 1 | 1 = trims are applied to the signal path |
| inj_sel_o | output | 4 | One-hot injection select of the active stage |
| mon_pull_o | output | 1 | Open-drain enable of the calibrated monitor |
| clr_start_o | output | 1 | One-cycle request to clear the start bit |

## Verification
The bench builds the block with its defaults: 6-bit trims and a 4-bit settle counter. Settle values 0 to 3 are driven at run time, so per-bit timing is checked both with a sample every cycle and with a held trial. Six-bit codes make the extremes 0 and 63 and a full 24-sample run cheap, so many random threshold sets fit beside the directed restart, sleep and bypass cases. The bench's comparator model compares the visible active trim with its chosen threshold.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
   localparam int NSTEP = 4;
   typedef enum logic [1:0] {
      STEP_OFFSET = 2'd0,
      STEP_DUTY   = 2'd1,
      STEP_RISE   = 2'd2,
      STEP_FALL   = 2'd3
   } step_e;
endpackage

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
   import calseq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   input  logic  sleep_i,
   input  logic  step_done_i,
   output logic  launch_o,
   output logic  busy_o,
   output step_e step_o,
   output logic  mon_o,
   output logic  clr_o
);
   logic start_q;
   logic adv;

   // start history is frozen while asleep so a request raised then fires on wake (R10)
   assign launch_o = start_i & ~start_q & ~sleep_i;
   assign adv      = busy_o & ~sleep_i & step_done_i & ~launch_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         busy_o  <= 1'b0;
         step_o  <= STEP_OFFSET;
         mon_o   <= 1'b0;
         clr_o   <= 1'b0;
      end else begin
         if (!sleep_i) start_q <= start_i;
         clr_o <= 1'b0;
         if (launch_o) begin
            busy_o <= 1'b1;
            step_o <= STEP_OFFSET;
            mon_o  <= 1'b0;
         end else if (adv) begin
            if (step_o == STEP_FALL) begin
               busy_o <= 1'b0;
               mon_o  <= 1'b1;
               clr_o  <= 1'b1;
            end else begin
               step_o <= step_e'(step_o + 2'd1);
            end
         end
      end
   end

   p_mon_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !mon_o);
   p_clr_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o |-> (mon_o && !busy_o));
   p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o |=> !clr_o);
   p_sleep_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && busy_o) |=> ($stable(step_o) && busy_o));
endmodule

// File: rtl/calseq_sar.sv
module calseq_sar #(
   parameter int TRIM_W = 6,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              busy_i,
   input  logic              hold_i,
   input  logic [CNT_W-1:0]  settle_i,
   input  logic              cmp_i,
   output logic [TRIM_W-1:0] code_o,
   output logic [TRIM_W-1:0] result_o,
   output logic              done_o
);
   localparam int IDX_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1;
   localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);
   localparam logic [IDX_W-1:0]  TOP = IDX_W'(TRIM_W - 1);

   logic [IDX_W-1:0]  idx;
   logic [CNT_W-1:0]  cnt;
   logic              sample;
   logic [TRIM_W-1:0] next_bit;

   assign sample   = busy_i & ~hold_i & (cnt == settle_i);
   assign done_o   = sample & (idx == '0);
   assign next_bit = TRIM_W'(1) << (idx - 1'b1);

   always_comb begin
      result_o      = code_o;
      result_o[idx] = ~cmp_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= MID;
         idx    <= TOP;
         cnt    <= '0;
      end else if (launch_i) begin
         code_o <= MID;
         idx    <= TOP;
         cnt    <= '0;
      end else if (busy_i && !hold_i) begin
         if (sample) begin
            cnt <= '0;
            if (idx == '0) begin
               code_o <= MID;
               idx    <= TOP;
            end else begin
               code_o <= result_o | next_bit;
               idx    <= idx - 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !launch_i) |=> $stable(code_o));
   p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (int'(idx) < TRIM_W));
endmodule

// File: rtl/calseq_trims.sv
module calseq_trims
   import calseq_pkg::*;
#(
   parameter int TRIM_W = 6,
   parameter int NUM    = NSTEP
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       launch_i,
   input  logic                       busy_i,
   input  step_e                      step_i,
   input  logic                       wr_i,
   input  logic [TRIM_W-1:0]          result_i,
   input  logic [TRIM_W-1:0]          code_i,
   output logic [NUM-1:0][TRIM_W-1:0] trim_o
);
   localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

   for (genvar k = 0; k < NUM; k++) begin : g_stage
      logic [TRIM_W-1:0] held;
      logic              active;
      assign active = busy_i && (int'(step_i) == k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                held <= MID;
         else if (launch_i)         held <= MID;
         else if (wr_i && active)   held <= result_i;
      end
      assign trim_o[k] = active ? code_i : held;
   end

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !launch_i) |=> $stable(trim_o));
   p_launch_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |=> (trim_o[NUM-1] == MID));
endmodule

// File: rtl/calseq_top.sv
module calseq_top
   import calseq_pkg::*;
#(
   parameter int TRIM_W = 6,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              bypass_i,
   input  logic              sleep_i,
   input  logic              cmp_i,
   input  logic [CNT_W-1:0]  settle_i,
   output logic [TRIM_W-1:0] trim_offset_o,
   output logic [TRIM_W-1:0] trim_duty_o,
   output logic [TRIM_W-1:0] trim_rise_o,
   output logic [TRIM_W-1:0] trim_fall_o,
   output logic              trim_apply_o,
   output logic [3:0]        inj_sel_o,
   output logic              mon_pull_o,
   output logic              clr_start_o
);
   if (TRIM_W < 2 || TRIM_W > 16) begin : g_bad_trim_w
      $error("calseq_top: TRIM_W must lie in 2..16");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("calseq_top: CNT_W must lie in 1..16");
   end

   logic                         launch, busy, done;
   step_e                        step;
   logic [TRIM_W-1:0]            code, result;
   logic [NSTEP-1:0][TRIM_W-1:0] trims;

   calseq_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sleep_i(sleep_i),
      .step_done_i(done), .launch_o(launch), .busy_o(busy), .step_o(step),
      .mon_o(mon_pull_o), .clr_o(clr_start_o)
   );

   calseq_sar #(.TRIM_W(TRIM_W), .CNT_W(CNT_W)) u_sar (
      .clk(clk), .rst_n(rst_n), .launch_i(launch), .busy_i(busy),
      .hold_i(sleep_i), .settle_i(settle_i), .cmp_i(cmp_i),
      .code_o(code), .result_o(result), .done_o(done)
   );

   calseq_trims #(.TRIM_W(TRIM_W), .NUM(NSTEP)) u_trims (
      .clk(clk), .rst_n(rst_n), .launch_i(launch), .busy_i(busy),
      .step_i(step), .wr_i(done), .result_i(result), .code_i(code),
      .trim_o(trims)
   );

   assign trim_offset_o = trims[STEP_OFFSET];
   assign trim_duty_o   = trims[STEP_DUTY];
   assign trim_rise_o   = trims[STEP_RISE];
   assign trim_fall_o   = trims[STEP_FALL];
   assign trim_apply_o  = ~bypass_i | busy;
   assign inj_sel_o     = busy ? (4'b0001 << step) : 4'b0000;

   p_inj_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inj_sel_o));
   p_mon_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_pull_o && !start_i) |=> mon_pull_o);
endmodule

// File: tb/sim_calseq_top.sv
module sim_calseq_top;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 6;
   localparam int CW   = 4;
   localparam int MIDV = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, bypass = 1'b0, sleep = 1'b0;
   logic [CW-1:0] settle = '0;
   logic          cmp;
   logic [W-1:0]  t_off, t_duty, t_rise, t_fall;
   logic          apply, mon, clr;
   logic [3:0]    inj;

   int tgt [4];
   int errors = 0;
   int checks = 0;

   calseq_top #(.TRIM_W(W), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .bypass_i(bypass),
      .sleep_i(sleep), .cmp_i(cmp), .settle_i(settle),
      .trim_offset_o(t_off), .trim_duty_o(t_duty), .trim_rise_o(t_rise),
      .trim_fall_o(t_fall), .trim_apply_o(apply), .inj_sel_o(inj),
      .mon_pull_o(mon), .clr_start_o(clr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // comparator model: high when the active trim exceeds its threshold
   always_comb begin
      case (inj)
         4'b0001: cmp = int'(t_off)  > tgt[0];
         4'b0010: cmp = int'(t_duty) > tgt[1];
         4'b0100: cmp = int'(t_rise) > tgt[2];
         4'b1000: cmp = int'(t_fall) > tgt[3];
         default: cmp = 1'b0;
      endcase
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_len(input int s);
      return 4 * W * (s + 1);
   endfunction

   task automatic check_trims(input string req);
      chk(req, int'(t_off),  tgt[0]);
      chk(req, int'(t_duty), tgt[1]);
      chk(req, int'(t_rise), tgt[2]);
      chk(req, int'(t_fall), tgt[3]);
   endtask

   // launch a run and follow it; optional sleep window and restart point
   task automatic run(input int slp_at, input int slp_len, input int rst_at,
                      input int extra);
      int  n = 0;
      int  i = 0;
      bit  seen = 0;
      logic [W-1:0] snap [4];
      start = 1'b1;
      while (i < 20000) begin
         @(negedge clk);
         start = 1'b0;
         if (inj == 4'b0000) break;
         n++;
         if (n == 1) begin
            chk("R5 monitor released", int'(mon), 0);
            chk("R2 fall trim preset", int'(t_fall), MIDV);
            chk("R2 offset trial", int'(t_off), MIDV);
            chk("R7 apply during run", int'(apply), 1);
            chk("R3 first stage", int'(inj), 1);
         end
         if (inj == 4'b0010 && !seen) begin
            seen = 1;
            chk("R11 finished stage", int'(t_off), tgt[0]);
            chk("R11 pending stage", int'(t_fall), MIDV);
         end
         if (i == slp_at) begin
            sleep = 1'b1;
            snap[0] = t_off; snap[1] = t_duty; snap[2] = t_rise; snap[3] = t_fall;
         end
         if (slp_len > 0 && i == slp_at + slp_len) begin
            chk("R9 frozen offset", int'(t_off),  int'(snap[0]));
            chk("R9 frozen duty",   int'(t_duty), int'(snap[1]));
            chk("R9 frozen rise",   int'(t_rise), int'(snap[2]));
            chk("R9 frozen fall",   int'(t_fall), int'(snap[3]));
            sleep = 1'b0;
         end
         if (i == rst_at) begin
            start = 1'b1;
            n = 0;
            seen = 0;
         end
         i++;
      end
      if (i >= 20000) begin
         errors++;
         $display("FAIL R4 run did not finish actual=%0d expected=%0d", i, exp_len(int'(settle)));
      end
      chk("R4 run length", n, exp_len(int'(settle)) + extra);
      chk("R6 clear pulse", int'(clr), 1);
      chk("R5 monitor driven", int'(mon), 1);
      check_trims("R4 final trims");
      @(negedge clk);
      chk("R6 clear single", int'(clr), 0);
      chk("R5 monitor held", int'(mon), 1);
   endtask

   task automatic set_tgt(input int a, input int b, input int c, input int d);
      tgt[0] = a; tgt[1] = b; tgt[2] = c; tgt[3] = d;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2718);
      set_tgt(0, 0, 0, 0);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 offset", int'(t_off), MIDV);
      chk("R1 duty", int'(t_duty), MIDV);
      chk("R1 rise", int'(t_rise), MIDV);
      chk("R1 fall", int'(t_fall), MIDV);
      chk("R1 monitor", int'(mon), 0);
      chk("R1 clear", int'(clr), 0);
      chk("R1 inject", int'(inj), 0);
      chk("R1 apply", int'(apply), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 extremes with a sample every cycle
      settle = 4'd0;
      set_tgt(0, 63, 1, 62);
      run(-1, 0, -1, 0);
      // R4 held trials
      settle = 4'd3;
      set_tgt(17, 45, 32, 31);
      run(-1, 0, -1, 0);

      // random thresholds and settle values
      for (int r = 0; r < 6; r++) begin
         settle = CW'($urandom_range(3, 0));
         set_tgt(int'($urandom_range(63, 0)), int'($urandom_range(63, 0)),
                 int'($urandom_range(63, 0)), int'($urandom_range(63, 0)));
         run(-1, 0, -1, 0);
      end

      // R8 restart mid-run
      settle = 4'd1;
      set_tgt(5, 50, 12, 40);
      run(-1, 0, 20, 0);

      // R9 sleep in the middle of a run adds exactly its length
      settle = 4'd2;
      set_tgt(9, 27, 44, 3);
      run(30, 7, -1, 7);

      // R9 idle sleep keeps trims; R10 start raised while asleep waits
      sleep = 1'b1;
      repeat (10) @(negedge clk);
      check_trims("R9 idle sleep retention");
      chk("R5 monitor kept in sleep", int'(mon), 1);
      start = 1'b1;
      set_tgt(60, 2, 33, 18);
      repeat (4) @(negedge clk);
      chk("R10 no launch asleep", int'(inj), 0);
      chk("R10 trims untouched", int'(t_off), 9);
      sleep = 1'b0;
      settle = 4'd0;
      run(-1, 0, -1, 0);

      // R7 run with bypass requested
      bypass = 1'b1;
      @(negedge clk);
      chk("R7 bypass idle", int'(apply), 0);
      set_tgt(21, 42, 7, 56);
      run(-1, 0, -1, 0);
      chk("R7 bypass after run", int'(apply), 0);
      bypass = 1'b0;
      @(negedge clk);
      chk("R7 bypass cleared", int'(apply), 1);
      check_trims("R7 trims kept");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule